// File: doc/BRIEF.md
# Dynamic Reconfiguration Register Slave

This block is a synchronous configuration-register slave. Fabric logic uses it to read and rewrite a tile's parameter words while the design runs. An access starts with a single-cycle enable strobe. The strobe carries a 7-bit address and a read/write select, plus 16 bits of write data when the access is a write. Reads return 16 bits on their own output bus. A one-cycle ready pulse closes every access after a latency that can be chosen per access.

Inside, a parameterized bank of 16-bit registers is indexed by address. Every register is also presented on a wide parameter bus for downstream logic. A clock-present input can stall an outstanding access: while it is low, the access stays pending and ready is held back. A sticky flag records any strobe that arrives while an access is still outstanding.

Top module: `cfg_port_slave`

## Requirements
- R1: On synchronous reset, register i is loaded with 16'hC000 | (i*16'h0101) (truncated to 16 bits), ready and the error flag go low, read data goes to zero, and any outstanding access is dropped with no ready pulse.
- R2: A write (enable high with select 1) updates the addressed register. The new value is visible on the parameter bus (register i at bits [16*i+15:16*i]) from the cycle in which ready is high.
- R3: A read (enable high with select 0) places the addressed register's value on the read-data bus in the cycle in which ready is high.
- R4: With latency code k (0 to 7), ready is high exactly k+1 clock edges after the edge that samples the enable, and only for one cycle.
- R5: Read data changes only together with the ready pulse of a read. Writes and idle cycles leave it holding the last value read.
- R6: An enable sampled while an access is outstanding has no effect on the registers or on the ready pulses. It sets the error flag, which stays high until the clear input is sampled high with no new violation on the same edge.
- R7: With 24 registers, addresses 24 to 127 read as zero and ignore writes, but still produce a ready pulse.
- R8: While the clock-present input is low, an outstanding access neither advances nor completes. Each edge it is low delays ready by one cycle.
- R9: Address, select, write data and latency code are captured on the enable edge. Later changes to those inputs do not alter the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | One-cycle access strobe |
| cfg_we | input | 1 | Access select: 1 write, 0 read |
| cfg_addr | input | 7 | Register address |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data, valid with ready |
| cfg_rdy | output | 1 | Completion / data-valid pulse |
| resp_lat | input | 3 | Latency code; ready follows after code+1 edges |
| refclk_ok | input | 1 | Clock-present; low stalls a pending access |
| err_clr | input | 1 | Clears the protocol-error flag |
| proto_err | output | 1 | Sticky flag for strobes during an outstanding access |
| param_bus | output | 384 | All register contents, register i at [16*i+15:16*i] |

## Verification
A corrupted latency counter shows up as a ready pulse in the wrong cycle, so the check fails at the first access. A wrong captured address or data word lands in the wrong slice of the parameter bus, or returns the wrong read value, on that access's ready cycle. A busy state that is lost or stuck shows up as an extra ready pulse, a missing ready pulse, or a spurious error flag one cycle after the next strobe. The bench times every ready pulse against its own cycle count.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

   localparam int IMG_BITS = 4096;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } cfgp_state_e;

   // reset image: word i = 0xC000 | i*0x0101, truncated to word width
   function automatic logic [IMG_BITS-1:0] default_image(input int n, input int w);
      logic [IMG_BITS-1:0] img;
      logic [31:0]         pat;
      img = '0;
      for (int i = 0; i < n; i++) begin
         pat = 32'hC000 | (i * 32'h0101);
         for (int j = 0; j < w; j++) begin
            if ((i * w + j) < IMG_BITS) img[i*w+j] = pat[j];
         end
      end
      return img;
   endfunction

endpackage

// File: rtl/cfgp_handshake.sv
module cfgp_handshake
   import cfgp_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 16,
   parameter int LAT_W  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [LAT_W-1:0]  lat,
   input  logic              clk_ok,
   input  logic              err_clr,
   output logic              done,
   output logic              done_we,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data,
   output logic              err
);

   cfgp_state_e       st_q;
   logic [LAT_W-1:0]  cnt_q;
   logic              we_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              err_q;
   logic              accept;
   logic              clash;

   assign accept  = en && (st_q == ST_IDLE);
   assign clash   = en && (st_q == ST_WAIT);
   assign done    = (st_q == ST_WAIT) && clk_ok && (cnt_q == '0);
   assign done_we = we_q;
   assign op_addr = addr_q;
   assign op_data = data_q;
   assign err     = err_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         we_q   <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else if (accept) begin
         st_q   <= ST_WAIT;
         cnt_q  <= lat;
         we_q   <= we;
         addr_q <= addr;
         data_q <= wdata;
      end else if (st_q == ST_WAIT && clk_ok) begin
         if (cnt_q == '0) st_q  <= ST_IDLE;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)          err_q <= 1'b0;
      else if (clash)   err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
   end

   // R8: a stalled access keeps its state and count
   p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_WAIT && !clk_ok) |=> (st_q == ST_WAIT && $stable(cnt_q)));

   // R6: a strobe during an outstanding access raises the flag
   p_err_set_r6: assert property (@(posedge clk) disable iff (rst)
      (en && st_q == ST_WAIT) |=> err_q);

   // R6: the flag stays up until cleared
   p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      (err_q && !err_clr) |=> err_q);

   // R9: captured fields do not move while the access is outstanding
   p_capture_stable_r9: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_WAIT) |=> ($stable(addr_q) && $stable(data_q) && $stable(we_q)));

endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile #(
   parameter int                          NUM_REGS = 24,
   parameter int                          ADDR_W   = 7,
   parameter int                          DATA_W   = 16,
   parameter logic [cfgp_pkg::IMG_BITS-1:0] RST_IMG = '0
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_stb,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [DATA_W-1:0]          rd_word,
   output logic [NUM_REGS*DATA_W-1:0] image
);

   localparam int SPAN = 1 << ADDR_W;

   logic [DATA_W-1:0] regs [NUM_REGS];
   logic              wr_ok;

   generate
      if (NUM_REGS < SPAN) begin : g_partial
         assign wr_ok = wr_stb && (wr_addr < ADDR_W'(NUM_REGS));
      end else begin : g_full
         assign wr_ok = wr_stb;
      end
   endgenerate

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)
            regs[i] <= RST_IMG[i*DATA_W +: DATA_W];
         else if (wr_ok && wr_addr == ADDR_W'(i))
            regs[i] <= wr_data;
      end
      assign image[i*DATA_W +: DATA_W] = regs[i];
   end

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_addr == ADDR_W'(i)) rd_word = regs[i];
      end
   end

   // R7: out-of-range writes leave every register unchanged
   p_oob_write_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_stb && (32'(wr_addr) >= NUM_REGS)) |=> $stable(image));

   // R2: nothing changes a register without a write strobe
   p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
      !wr_stb |=> $stable(image));

endmodule

// File: rtl/cfgp_respond.sv
module cfgp_respond #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              done,
   input  logic              done_we,
   input  logic [DATA_W-1:0] rd_word,
   output logic              rdy,
   output logic [DATA_W-1:0] rdata
);

   logic              rdy_q;
   logic [DATA_W-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         rdy_q <= 1'b0;
         rd_q  <= '0;
      end else begin
         rdy_q <= done;
         if (done && !done_we) rd_q <= rd_word;
      end
   end

   assign rdy   = rdy_q;
   assign rdata = rd_q;

   // R4: ready is a single-cycle pulse
   p_rdy_pulse_r4: assert property (@(posedge clk) disable iff (rst)
      rdy_q |=> !rdy_q);

   // R5: read data only moves with a ready pulse
   p_rdata_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !$stable(rd_q) |-> rdy_q);

endmodule

// File: rtl/cfg_port_slave.sv
module cfg_port_slave
   import cfgp_pkg::*;
#(
   parameter int                   NUM_REGS = 24,
   parameter int                   ADDR_W   = 7,
   parameter int                   DATA_W   = 16,
   parameter int                   LAT_W    = 3,
   parameter logic [IMG_BITS-1:0]  RST_IMG  = default_image(NUM_REGS, DATA_W)
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       cfg_en,
   input  logic                       cfg_we,
   input  logic [ADDR_W-1:0]          cfg_addr,
   input  logic [DATA_W-1:0]          cfg_wdata,
   output logic [DATA_W-1:0]          cfg_rdata,
   output logic                       cfg_rdy,
   input  logic [LAT_W-1:0]           resp_lat,
   input  logic                       refclk_ok,
   input  logic                       err_clr,
   output logic                       proto_err,
   output logic [NUM_REGS*DATA_W-1:0] param_bus
);

   if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_count
      $error("cfg_port_slave: NUM_REGS outside address space");
   end
   if (NUM_REGS * DATA_W > IMG_BITS) begin : g_bad_image
      $error("cfg_port_slave: reset image too small");
   end
   if (DATA_W > 32 || LAT_W < 1) begin : g_bad_width
      $error("cfg_port_slave: unsupported width");
   end

   logic              done;
   logic              done_we;
   logic [ADDR_W-1:0] op_addr;
   logic [DATA_W-1:0] op_data;
   logic [DATA_W-1:0] rd_word;

   cfgp_handshake #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LAT_W  (LAT_W)
   ) u_hs (
      .clk     (clk),
      .rst     (rst),
      .en      (cfg_en),
      .we      (cfg_we),
      .addr    (cfg_addr),
      .wdata   (cfg_wdata),
      .lat     (resp_lat),
      .clk_ok  (refclk_ok),
      .err_clr (err_clr),
      .done    (done),
      .done_we (done_we),
      .op_addr (op_addr),
      .op_data (op_data),
      .err     (proto_err)
   );

   cfgp_regfile #(
      .NUM_REGS (NUM_REGS),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .RST_IMG  (RST_IMG)
   ) u_rf (
      .clk     (clk),
      .rst     (rst),
      .wr_stb  (done && done_we),
      .wr_addr (op_addr),
      .wr_data (op_data),
      .rd_addr (op_addr),
      .rd_word (rd_word),
      .image   (param_bus)
   );

   cfgp_respond #(
      .DATA_W (DATA_W)
   ) u_rsp (
      .clk     (clk),
      .rst     (rst),
      .done    (done),
      .done_we (done_we),
      .rd_word (rd_word),
      .rdy     (cfg_rdy),
      .rdata   (cfg_rdata)
   );

   // R1: the cycle after reset shows no ready and no error
   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> (!cfg_rdy && !proto_err));

endmodule

// File: tb/test_cfg_port_slave.sv
`timescale 1ns/1ps
module test_cfg_port_slave;

   localparam int NREG = 24;

   typedef struct {
      int          exp_cyc;
      bit          is_rd;
      logic [15:0] exp_d;
   } item_t;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             cfg_en = 1'b0;
   logic             cfg_we = 1'b0;
   logic [6:0]       cfg_addr = '0;
   logic [15:0]      cfg_wdata = '0;
   logic [15:0]      cfg_rdata;
   logic             cfg_rdy;
   logic [2:0]       resp_lat = '0;
   logic             refclk_ok = 1'b1;
   logic             err_clr = 1'b0;
   logic             proto_err;
   logic [NREG*16-1:0] param_bus;

   int          n_chk = 0;
   int          n_bad = 0;
   int          cyc = 0;
   item_t       sb[$];
   logic [15:0] mdl [128];
   logic [15:0] last_rd = '0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cfg_port_slave i_cfg_port_slave (
      .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .cfg_rdy(cfg_rdy), .resp_lat(resp_lat), .refclk_ok(refclk_ok),
      .err_clr(err_clr), .proto_err(proto_err), .param_bus(param_bus));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] dflt(input int i);
      logic [31:0] v;
      v = 32'hC000 | (i * 32'h0101);
      return v[15:0];
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 128; i++) mdl[i] = (i < NREG) ? dflt(i) : 16'h0000;
      last_rd = '0;
   endtask

   task automatic check_bus(input string tag);
      bit ok;
      ok = 1'b1;
      for (int i = 0; i < NREG; i++)
         if (param_bus[i*16 +: 16] !== mdl[i]) ok = 1'b0;
      chk(ok, tag, {16'h0, param_bus[15:0]}, {16'h0, mdl[0]});
   endtask

   // monitor: pops one expected item per ready pulse
   always @(negedge clk) begin
      if (!rst && cfg_rdy) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R6 unexpected ready", 32'(cyc), 32'hFFFF_FFFF);
         end else begin
            item_t it;
            it = sb.pop_front();
            chk(cyc == it.exp_cyc, "R4 ready timing", 32'(cyc), 32'(it.exp_cyc));
            if (it.is_rd) begin
               chk(cfg_rdata === it.exp_d, "R3 read data", {16'h0, cfg_rdata}, {16'h0, it.exp_d});
               last_rd = it.exp_d;
            end
         end
      end
   end

   task automatic wait_idle();
      while (sb.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   // driver: one access; stall = edges with clock-present low while pending
   task automatic do_op(input bit we, input int a, input logic [15:0] d,
                        input int lat, input int stall);
      item_t it;
      wait_idle();
      cfg_en = 1'b1; cfg_we = we; cfg_addr = 7'(a); cfg_wdata = d;
      resp_lat = 3'(lat);
      it.exp_cyc = cyc + 1 + lat + 1 + stall;
      it.is_rd   = !we;
      it.exp_d   = mdl[a];
      if (we && a < NREG) mdl[a] = d;
      sb.push_back(it);
      if (stall > 0) refclk_ok = 1'b0;
      @(negedge clk);
      cfg_en = 1'b0; cfg_we = ~we; cfg_addr = ~cfg_addr;
      cfg_wdata = ~d; resp_lat = ~resp_lat;                 // R9 disturb
      for (int s = 0; s < stall; s++) @(negedge clk);
      refclk_ok = 1'b1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog", 32'(cyc), 32'd0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(!cfg_rdy && !proto_err, "R1 reset flags", {30'h0, cfg_rdy, proto_err}, 32'h0);
      chk(cfg_rdata === 16'h0, "R1 reset rdata", {16'h0, cfg_rdata}, 32'h0);
      check_bus("R1 reset image");

      // R3/R4 reads at several latencies
      for (int k = 0; k < 8; k++) do_op(1'b0, k * 3, 16'h0, k, 0);
      // R2 writes with R9 disturbance
      do_op(1'b1, 5, 16'h1234, 0, 0);
      do_op(1'b1, 23, 16'hBEEF, 7, 0);
      do_op(1'b1, 0, 16'h0F0F, 3, 0);
      wait_idle();
      check_bus("R2 image after writes");
      chk(cfg_rdata === last_rd, "R5 hold after writes", {16'h0, cfg_rdata}, {16'h0, last_rd});
      do_op(1'b0, 5, 16'h0, 2, 0);
      do_op(1'b0, 23, 16'h0, 1, 0);
      wait_idle();
      repeat (4) @(negedge clk);
      chk(cfg_rdata === 16'hBEEF, "R5 hold idle", {16'h0, cfg_rdata}, 32'hBEEF);

      // R7 out of range
      do_op(1'b1, 24, 16'hAAAA, 1, 0);
      do_op(1'b1, 127, 16'h5555, 0, 0);
      do_op(1'b0, 24, 16'h0, 0, 0);
      do_op(1'b0, 100, 16'h0, 4, 0);
      wait_idle();
      check_bus("R7 image unchanged");

      // R8 clock-present stall
      do_op(1'b1, 7, 16'h7777, 2, 5);
      do_op(1'b0, 7, 16'h0, 0, 3);
      wait_idle();
      check_bus("R8 image after stall");

      // R6 strobe during outstanding access
      wait_idle();
      begin
         item_t it;
         cfg_en = 1'b1; cfg_we = 1'b1; cfg_addr = 7'd3; cfg_wdata = 16'h3333; resp_lat = 3'd6;
         it.exp_cyc = cyc + 1 + 7; it.is_rd = 1'b0; it.exp_d = '0;
         mdl[3] = 16'h3333;
         sb.push_back(it);
         @(negedge clk);
         cfg_en = 1'b0;
         @(negedge clk);
         chk(!proto_err, "R6 no error yet", {31'h0, proto_err}, 32'h0);
         cfg_en = 1'b1; cfg_we = 1'b1; cfg_addr = 7'd3; cfg_wdata = 16'hDEAD;
         @(negedge clk);
         cfg_en = 1'b0;
         chk(proto_err, "R6 error set", {31'h0, proto_err}, 32'h1);
      end
      wait_idle();
      repeat (3) @(negedge clk);
      check_bus("R6 intruder write ignored");
      chk(proto_err, "R6 error sticky", {31'h0, proto_err}, 32'h1);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      chk(!proto_err, "R6 error cleared", {31'h0, proto_err}, 32'h0);

      // R1 reset drops an outstanding access
      wait_idle();
      cfg_en = 1'b1; cfg_we = 1'b1; cfg_addr = 7'd9; cfg_wdata = 16'h9999; resp_lat = 3'd7;
      @(negedge clk);
      cfg_en = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      model_reset();
      repeat (12) @(negedge clk);
      check_bus("R1 access dropped by reset");
      chk(cfg_rdata === 16'h0 && !proto_err, "R1 state after reset",
          {15'h0, proto_err, cfg_rdata}, 32'h0);
      do_op(1'b0, 9, 16'h0, 1, 0);
      wait_idle();

      chk(sb.size() == 0, "R4 all ready seen", 32'(sb.size()), 32'h0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule